// File: doc/BRIEF.md
# Shared Queue with Arbitrated Write and Read Ports

This block is a first-in first-out buffer of fixed depth and data width. It carries data between parallel logic regions that share one clock. Several producers each have a write port and several consumers each have a read port. Each port raises a request for one cycle, or holds it for several. A round-robin arbiter on the write side and a separate one on the read side choose at most one port per side to serve in a cycle. One write and one read can therefore finish in the same cycle.

Each served port gets its result on registered outputs in the cycle after it is served. A served writer sees either an accept pulse or a refusal pulse. A refusal means the queue already held DEPTH elements, and the word was dropped without disturbing the stored data. A served reader sees either a valid pulse, with the word on the shared read data bus, or an empty pulse. A port that is not served gets no response and should keep its request up.

A build-time parameter sets the arbitration mode for every port of the instance:
- Always-arbitrate: a request is served no earlier than its second consecutive cycle.
- Multi-only: a request is served in the same cycle whenever it can be, so a lone requestor completes every clock.
- Never-arbitrate: only port 0 of each side is served, and requests on any other port raise an error flag.

Top module: `shared_queue`

## Requirements
- R1: Words leave in the order they were accepted. A served read with data present pulses that port's `rd_valid` one cycle later, with the oldest stored word on `rd_data`. Up to DEPTH words can be held.
- R2: Each side serves at most one port per cycle, and only a port whose request is high. A served write port sees exactly one of `wr_done` or `wr_full` high in the next cycle. A port that is not served sees neither.
- R3: A served write that finds DEPTH words already stored at the start of that cycle is refused: that port's `wr_full` pulses and `wr_done` stays low. This holds even when a read completes in the same cycle. The stored words and their order are unchanged.
- R4: A served read that finds the queue empty at the start of that cycle pulses that port's `rd_empty`, and `rd_valid` stays low. This holds even when a write completes in the same cycle.
- R5: A write and a read may both complete in the same cycle. Contention among writers never delays a read, and contention among readers never delays a write.
- R6: Among ports that are eligible together, the grant goes to the first eligible port above the most recently served port on that side, wrapping from the highest index to 0. After reset, port 0 comes first.
- R7: In multi-only mode (the default), a request is served in the cycle it is raised if no higher-priority port under R6 competes. Its response appears on the next clock edge.
- R8: In always-arbitrate mode, a port is eligible only when its request was also high in the previous cycle. A lone request raised for the first time therefore gets its response two cycles after it is raised.
- R9: In never-arbitrate mode, only port 0 of each side is served. A request on any other port is not served and stores or removes nothing. It pulses `arb_err` in the next cycle. In the other two modes `arb_err` stays low.
- R10: A synchronous active-high reset empties the queue, returns both arbiters to their initial priority, and drives every response output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_req | input | N_WR | Write request, one bit per write port |
| wr_data | input | N_WR*DATA_W | Write words; port i uses bits [i*DATA_W +: DATA_W] |
| rd_req | input | N_RD | Read request, one bit per read port |
| wr_done | output | N_WR | Pulse: the port's word was stored |
| wr_full | output | N_WR | Pulse: the port was served but refused because the queue was full |
| rd_valid | output | N_RD | Pulse: the port received a word on rd_data |
| rd_empty | output | N_RD | Pulse: the port was served but the queue was empty |
| rd_data | output | DATA_W | Word delivered to the port whose rd_valid is high |
| arb_err | output | 1 | Pulse: a port other than 0 made a request in never-arbitrate mode |

## Verification
The bench first runs directed patterns:
- writing to full and then writing and reading together, which separates start-of-cycle refusal from a full check applied after the read;
- reading an empty queue;
- all writers requesting at once, which shows whether the rotation starts past the last served port or restarts at port 0.

A long seeded random stream follows, with mixed multi-port write and read requests. It is checked against a queue model with its own round-robin pointers. This catches ordering, lost or duplicated words, and grant skew. Two further instances, one in always-arbitrate mode and one in never-arbitrate mode, get directed requests. These show the one-cycle eligibility delay, and show that port 1 is ignored and flagged and that its word never enters storage.

// File: rtl/sq_pkg.sv
package sq_pkg;

    // Arbitration policy shared by every port of one queue instance.
    typedef enum logic [1:0] {
        ARB_ALWAYS = 2'd0,
        ARB_MULTI  = 2'd1,
        ARB_NONE   = 2'd2
    } arb_mode_e;

endpackage

// File: rtl/sq_rr_arb.sv
module sq_rr_arb
    import sq_pkg::*;
#(
    parameter int        N    = 2,
    parameter arb_mode_e MODE = ARB_MULTI
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         misuse
);

    localparam int PW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [PW-1:0] last;   // index of most recently served port
        logic [N-1:0]  seen;   // request vector of the previous cycle
    } arb_st_t;

    arb_st_t     st_d, st_q;
    logic [N-1:0] elig;

    always_comb begin
        int idx;
        st_d      = st_q;
        st_d.seen = req;
        gnt       = '0;
        misuse    = 1'b0;
        elig      = req;
        idx       = 0;
        if (MODE == ARB_ALWAYS) begin
            elig = req & st_q.seen;
        end
        if (MODE == ARB_NONE) begin
            gnt[0] = req[0];
            for (int i = 1; i < N; i++) begin
                if (req[i]) misuse = 1'b1;
            end
        end else begin
            for (int off = 1; off <= N; off++) begin
                idx = (int'(st_q.last) + off) % N;
                if (elig[idx] && (gnt == '0)) begin
                    gnt[idx]  = 1'b1;
                    st_d.last = PW'(idx);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.last <= PW'(N - 1);
            st_q.seen <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R2
    gnt_requested_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

    generate
        if (MODE == ARB_MULTI) begin : g_multi_chk
            // R7
            lone_fast_chk: assert property (@(posedge clk) disable iff (rst)
                ($countones(req) == 1) |-> (gnt == req));
        end
        if (MODE == ARB_ALWAYS) begin : g_always_chk
            // R8
            held_req_chk: assert property (@(posedge clk) disable iff (rst)
                (gnt != '0) |-> ((gnt & $past(req)) == gnt));
        end
        if (MODE == ARB_NONE) begin : g_none_chk
            // R9
            port0_only_chk: assert property (@(posedge clk) disable iff (rst)
                (gnt >> 1) == '0);
        end
    endgenerate

endmodule

// File: rtl/sq_store.sv
module sq_store #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         full,
    output logic         empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } store_st_t;

    store_st_t    st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic         do_push, do_pop;

    assign full     = (st_q.count == CW'(DEPTH));
    assign empty    = (st_q.count == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = mem[st_q.rd_ptr];

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.wr_ptr = (st_q.wr_ptr == AW'(DEPTH - 1)) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == AW'(DEPTH - 1)) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[st_q.wr_ptr] <= push_data;
        end
    end

    // R1
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.count <= CW'(DEPTH));

    // R3
    full_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> $stable(st_q.count));

    // R5
    both_ways_chk: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !full && !empty) |=> $stable(st_q.count));

endmodule

// File: rtl/shared_queue.sv
module shared_queue
    import sq_pkg::*;
#(
    parameter int        DATA_W = 8,
    parameter int        DEPTH  = 8,
    parameter int        N_WR   = 3,
    parameter int        N_RD   = 2,
    parameter arb_mode_e MODE   = ARB_MULTI
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_WR-1:0]          wr_req,
    input  logic [N_WR*DATA_W-1:0]   wr_data,
    input  logic [N_RD-1:0]          rd_req,
    output logic [N_WR-1:0]          wr_done,
    output logic [N_WR-1:0]          wr_full,
    output logic [N_RD-1:0]          rd_valid,
    output logic [N_RD-1:0]          rd_empty,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     arb_err
);

    typedef struct packed {
        logic [N_WR-1:0]   wdone;
        logic [N_WR-1:0]   wfull;
        logic [N_RD-1:0]   rvalid;
        logic [N_RD-1:0]   rempty;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } resp_t;

    resp_t             rsp_d, rsp_q;
    logic [N_WR-1:0]   wgnt;
    logic [N_RD-1:0]   rgnt;
    logic              werr, rerr;
    logic              q_full, q_empty;
    logic [DATA_W-1:0] sel_data, head_data;
    logic              push, pop;

    sq_rr_arb #(.N(N_WR), .MODE(MODE)) wr_arb_i (
        .clk    (clk),
        .rst    (rst),
        .req    (wr_req),
        .gnt    (wgnt),
        .misuse (werr)
    );

    sq_rr_arb #(.N(N_RD), .MODE(MODE)) rd_arb_i (
        .clk    (clk),
        .rst    (rst),
        .req    (rd_req),
        .gnt    (rgnt),
        .misuse (rerr)
    );

    always_comb begin
        sel_data = '0;
        for (int i = 0; i < N_WR; i++) begin
            if (wgnt[i]) sel_data = sel_data | wr_data[i*DATA_W +: DATA_W];
        end
    end

    assign push = (wgnt != '0);
    assign pop  = (rgnt != '0);

    sq_store #(.W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (sel_data),
        .pop       (pop),
        .pop_data  (head_data),
        .full      (q_full),
        .empty     (q_empty)
    );

    always_comb begin
        rsp_d        = rsp_q;
        rsp_d.wdone  = wgnt & {N_WR{!q_full}};
        rsp_d.wfull  = wgnt & {N_WR{q_full}};
        rsp_d.rvalid = rgnt & {N_RD{!q_empty}};
        rsp_d.rempty = rgnt & {N_RD{q_empty}};
        rsp_d.err    = werr | rerr;
        if (pop && !q_empty) begin
            rsp_d.rdata = head_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign wr_done  = rsp_q.wdone;
    assign wr_full  = rsp_q.wfull;
    assign rd_valid = rsp_q.rvalid;
    assign rd_empty = rsp_q.rempty;
    assign rd_data  = rsp_q.rdata;
    assign arb_err  = rsp_q.err;

    // R2
    wr_resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(wr_done | wr_full) <= 1 && (wr_done & wr_full) == '0);

    // R4
    rd_resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(rd_valid | rd_empty) <= 1 && (rd_valid & rd_empty) == '0);

    // R2
    wr_resp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req == '0) |=> (wr_done == '0 && wr_full == '0));

    generate
        if (MODE != ARB_NONE) begin : g_err_chk
            // R9
            no_err_chk: assert property (@(posedge clk) disable iff (rst)
                !arb_err);
        end
    endgenerate

endmodule

// File: tb/shared_queue_tb_top.sv
module shared_queue_tb_top;
    import sq_pkg::*;

    localparam int DW = 8;
    localparam int DP = 4;
    localparam int NW = 3;
    localparam int NR = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [NW-1:0] i_wreq = '0, i_wdone, i_wfull;
    logic [NW*DW-1:0] i_wdat = '0;
    logic [NR-1:0] i_rreq = '0, i_rvalid, i_rempty;
    logic [DW-1:0] i_rdata;
    logic i_err;

    logic [NW-1:0] a_wreq = '0, a_wdone, a_wfull;
    logic [NW*DW-1:0] a_wdat = '0;
    logic [NR-1:0] a_rreq = '0, a_rvalid, a_rempty;
    logic [DW-1:0] a_rdata;
    logic a_err;

    logic [NW-1:0] n_wreq = '0, n_wdone, n_wfull;
    logic [NW*DW-1:0] n_wdat = '0;
    logic [NR-1:0] n_rreq = '0, n_rvalid, n_rempty;
    logic [DW-1:0] n_rdata;
    logic n_err;

    shared_queue #(.DATA_W(DW), .DEPTH(DP), .N_WR(NW), .N_RD(NR), .MODE(ARB_MULTI)) dut_i (
        .clk(clk), .rst(rst), .wr_req(i_wreq), .wr_data(i_wdat), .rd_req(i_rreq),
        .wr_done(i_wdone), .wr_full(i_wfull), .rd_valid(i_rvalid), .rd_empty(i_rempty),
        .rd_data(i_rdata), .arb_err(i_err));

    shared_queue #(.DATA_W(DW), .DEPTH(DP), .N_WR(NW), .N_RD(NR), .MODE(ARB_ALWAYS)) dut_a (
        .clk(clk), .rst(rst), .wr_req(a_wreq), .wr_data(a_wdat), .rd_req(a_rreq),
        .wr_done(a_wdone), .wr_full(a_wfull), .rd_valid(a_rvalid), .rd_empty(a_rempty),
        .rd_data(a_rdata), .arb_err(a_err));

    shared_queue #(.DATA_W(DW), .DEPTH(DP), .N_WR(NW), .N_RD(NR), .MODE(ARB_NONE)) dut_n (
        .clk(clk), .rst(rst), .wr_req(n_wreq), .wr_data(n_wdat), .rd_req(n_rreq),
        .wr_done(n_wdone), .wr_full(n_wfull), .rd_valid(n_rvalid), .rd_empty(n_rempty),
        .rd_data(n_rdata), .arb_err(n_err));

    int n_chk  = 0;
    int n_fail = 0;
    int wlast  = NW - 1;
    int rlast  = NR - 1;
    logic [DW-1:0] mq[$];

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic int rr_pick(input int n, input logic [7:0] req, input int last);
        for (int off = 1; off <= n; off++) begin
            int idx;
            idx = (last + off) % n;
            if (req[idx]) return idx;
        end
        return -1;
    endfunction

    // One cycle on dut_i, checked against the reference queue model.
    task automatic step(input logic [NW-1:0] wr, input logic [NW*DW-1:0] wd, input logic [NR-1:0] rd);
        int wg, rg;
        logic full, empty;
        logic [NW-1:0] e_wdone, e_wfull;
        logic [NR-1:0] e_rvalid, e_rempty;
        logic [DW-1:0] e_rdata;
        wg = rr_pick(NW, 8'(wr), wlast);
        rg = rr_pick(NR, 8'(rd), rlast);
        full  = (mq.size() == DP);
        empty = (mq.size() == 0);
        e_wdone = '0; e_wfull = '0; e_rvalid = '0; e_rempty = '0; e_rdata = '0;
        if (wg >= 0) begin
            if (full) e_wfull[wg] = 1'b1; else e_wdone[wg] = 1'b1;
            wlast = wg;
        end
        if (rg >= 0) begin
            if (empty) e_rempty[rg] = 1'b1;
            else begin
                e_rvalid[rg] = 1'b1;
                e_rdata = mq[0];
            end
            rlast = rg;
        end
        if (rg >= 0 && !empty) void'(mq.pop_front());
        if (wg >= 0 && !full) mq.push_back(wd[wg*DW +: DW]);
        i_wreq = wr; i_wdat = wd; i_rreq = rd;
        @(posedge clk);
        @(negedge clk);
        i_wreq = '0; i_rreq = '0;
        chk("R2 R6 R7 wr_done", 32'(i_wdone), 32'(e_wdone));
        chk("R3 wr_full", 32'(i_wfull), 32'(e_wfull));
        chk("R1 R5 rd_valid", 32'(i_rvalid), 32'(e_rvalid));
        chk("R4 rd_empty", 32'(i_rempty), 32'(e_rempty));
        if (e_rvalid != '0) chk("R1 rd_data", 32'(i_rdata), 32'(e_rdata));
        chk("R9 arb_err low in multi mode", 32'(i_err), 32'h0);
    endtask

    function automatic logic [NW*DW-1:0] pack3(input logic [DW-1:0] d0, input logic [DW-1:0] d1, input logic [DW-1:0] d2);
        return {d2, d1, d0};
    endfunction

    initial begin : wdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 wr_done after reset", 32'(i_wdone), 32'h0);
        chk("R10 wr_full after reset", 32'(i_wfull), 32'h0);
        chk("R10 rd_valid after reset", 32'(i_rvalid), 32'h0);
        chk("R10 rd_empty after reset", 32'(i_rempty), 32'h0);
        chk("R10 arb_err after reset", 32'(n_err), 32'h0);

        // R4 read from empty queue right after reset
        step('0, '0, 2'b01);
        // R1 R3 fill to DEPTH from port 2, then refuse while reading (R5)
        for (int k = 0; k < DP; k++) step(3'b100, pack3(8'h00, 8'h00, 8'(8'hA0 + k)), '0);
        step(3'b001, pack3(8'hEE, 8'h00, 8'h00), 2'b10);
        step(3'b001, pack3(8'hE1, 8'h00, 8'h00), 2'b00);
        // R6 all writers at once, rotation continues past last served
        for (int k = 0; k < 4; k++) step('0, '0, 2'b11);
        for (int k = 0; k < 4; k++) step(3'b111, pack3(8'(8'h10 + k), 8'(8'h20 + k), 8'(8'h30 + k)), 2'b11);
        for (int k = 0; k < 6; k++) step('0, '0, 2'b11);

        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic [NW-1:0] wr;
            logic [NR-1:0] rd;
            wr = NW'($urandom % 8);
            rd = NR'($urandom % 4);
            if (($urandom % 4) == 0) rd = '0;
            if (($urandom % 5) == 0) wr = '0;
            step(wr, NW*DW'($urandom), rd);
        end

        // R8 always-arbitrate: lone request waits one extra cycle
        a_wreq = 3'b010; a_wdat = pack3(8'h00, 8'h5A, 8'h00);
        @(posedge clk); @(negedge clk);
        chk("R8 no write response one cycle after first request", 32'(a_wdone | a_wfull), 32'h0);
        @(posedge clk); @(negedge clk);
        a_wreq = '0;
        chk("R8 write done on second cycle", 32'(a_wdone), 32'h2);
        a_rreq = 2'b01;
        @(posedge clk); @(negedge clk);
        chk("R8 no read response one cycle after first request", 32'(a_rvalid | a_rempty), 32'h0);
        @(posedge clk); @(negedge clk);
        a_rreq = '0;
        chk("R8 read valid on second cycle", 32'(a_rvalid), 32'h1);
        chk("R8 read data", 32'(a_rdata), 32'h5A);
        chk("R9 arb_err low in always mode", 32'(a_err), 32'h0);

        // R9 never-arbitrate: port 1 ignored and flagged
        n_wreq = 3'b011; n_wdat = pack3(8'h11, 8'h22, 8'h00);
        @(posedge clk); @(negedge clk);
        n_wreq = '0;
        chk("R9 only port 0 written", 32'(n_wdone), 32'h1);
        chk("R9 error flag on port 1 write", 32'(n_err), 32'h1);
        n_rreq = 2'b11;
        @(posedge clk); @(negedge clk);
        n_rreq = '0;
        chk("R9 only port 0 read", 32'(n_rvalid), 32'h1);
        chk("R9 port 0 word", 32'(n_rdata), 32'h11);
        chk("R9 error flag on port 1 read", 32'(n_err), 32'h1);
        n_rreq = 2'b01;
        @(posedge clk); @(negedge clk);
        n_rreq = '0;
        chk("R9 port 1 word never stored", 32'(n_rempty), 32'h1);
        chk("R9 no error for port 0 alone", 32'(n_err), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule